// File: doc/BRIEF.md
# Reset-Cause and Wake-Up Sequencer

This block sits beside the core of a small 8-bit controller and decides, from a handful of raw event lines, what kind of restart or wake-up has just taken place. It watches a power-on reset, an active-low master-clear pin, a watchdog time-out pulse, a sleep flag from the core, and an interrupt-pending flag with its global enable. For each accepted event it raises a one-cycle update strobe. Along with the strobe it gives the cause (encoded and one-hot), the value the program counter must take, and a new status byte. The two flag bits in that byte tell software whether a time-out happened (bit 4) and whether the core was powered down (bit 3).

The master-clear pin is synchronised and then filtered, so that glitches never reach the core. Restarts that clear the machine also hold a chip reset level until a start-up delay of 2^DLY_W clock cycles has run out. A watchdog event or an interrupt while the core sleeps is treated as the core carrying on: the program counter steps forward or jumps to the interrupt vector, and the chip reset stays low. The core loads `pc_val_o` and `status_o` in every cycle that `evt_o` is high. There is no back-pressure.

Top module: `rstwake_ctrl`

## Requirements
- R1: While `por_i` is high, the block presents `evt_o`=1, cause 1, `pc_val_o`=0 and `status_o`=8'b0001_1000, with the unknown low bits driven 0. `chip_rst_o` stays high for exactly 2^DLY_W rising edges after `por_i` falls.
- R2: A low on `mclr_n_i` is accepted only after FILT_N consecutive low samples of the two-flop synchronised pin. A low lasting fewer than FILT_N cycles has no effect on any output.
- R3: An accepted master-clear fall while `sleep_i`=0 gives one event with cause 2, pc 0 and status {3'b000, status_i[4:0]}. A pin that is held low produces no further events.
- R4: An accepted master-clear fall while `sleep_i`=1 gives cause 3, pc 0 and status {3'b000, 1, 0, status_i[2:0]}.
- R5: A watchdog pulse while `sleep_i`=0 gives cause 4, pc 0 and status {5'b00001, status_i[2:0]}, and raises `chip_rst_o` in the event cycle.
- R6: A watchdog pulse while `sleep_i`=1 gives cause 5, pc = `pc_i`+1 (wrapping modulo 2^PCW) and status {status_i[7:5], 0, 0, status_i[2:0]}, with `chip_rst_o` low.
- R7: `int_pend_i` with `sleep_i`=1 gives cause 6 and status {status_i[7:5], 1, 0, status_i[2:0]}, with `chip_rst_o` low. The pc becomes IRQ_VEC (4) when `gie_i`=1 and `pc_i`+1 otherwise. `int_pend_i` with `sleep_i`=0 causes no event.
- R8: When causes coincide, power-on wins over master-clear, master-clear over watchdog, and watchdog over interrupt.
- R9: `cause_oh_o` bit k is set exactly when `evt_o`=1 and the cause equals k+1. Cause values: 1 power-on, 2 pin run, 3 pin sleep, 4 watchdog run, 5 watchdog wake, 6 interrupt wake.
- R10: After a master-clear, `chip_rst_o` stays high while the filtered pin is low. Once the filter sees the pin high again, it stays high for 2^DLY_W more edges, which is FILT_N+2+2^DLY_W edges after the pin rises.
- R11: While `chip_rst_o` is high, watchdog and interrupt inputs produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| mclr_n_i | input | 1 | Master-clear pin, active low, asynchronous |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| sleep_i | input | 1 | Core is in sleep mode |
| int_pend_i | input | 1 | Interrupt pending |
| gie_i | input | 1 | Global interrupt enable |
| pc_i | input | PCW | Current program counter |
| status_i | input | 8 | Current status byte |
| evt_o | output | 1 | Update strobe: load pc and status |
| cause_o | output | 3 | Encoded cause (R9) |
| cause_oh_o | output | 6 | One-hot cause |
| pc_val_o | output | PCW | Program counter value to load |
| status_o | output | 8 | Status byte to load |
| chip_rst_o | output | 1 | Chip-wide register reset level |

## Verification
The bench sends a master-clear low that lasts one cycle less than the filter length, and then one of exactly the filter length. A filter that is off by one would either let the short glitch reset the chip or miss the valid press. It measures the exact edge on which the chip reset releases, both after power-on and after a master-clear. A counter with the wrong terminal value, or one that restarts late, would move that edge. It drives watchdog and interrupt pulses during sleep, during the start-up delay and with the pc at its top value, which catches a wake that resets the chip, an event that slips through the delay, and pc arithmetic that does not wrap. It also sends a watchdog pulse and an interrupt in the same cycle, where a wrong priority would report an interrupt wake.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;
  typedef enum logic [2:0] {
    CZ_NONE     = 3'd0,
    CZ_POR      = 3'd1,
    CZ_PIN_RUN  = 3'd2,
    CZ_PIN_SLP  = 3'd3,
    CZ_WD_RUN   = 3'd4,
    CZ_WD_WAKE  = 3'd5,
    CZ_IRQ_WAKE = 3'd6
  } cause_e;

  localparam int NCAUSE = 6;
  localparam logic [7:0] POR_STATUS = 8'b0001_1000;
endpackage

// File: rtl/rw_pin_filter.sv
module rw_pin_filter #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  output logic filt_n_o,
  output logic fall_o
);
  localparam int CW = $clog2(N + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;
  logic          at_lim;

  assign at_lim = (run_q == CW'(N - 1));
  assign fall_o = filt_n_o && !s2_q && at_lim;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      s1_q     <= 1'b1;
      s2_q     <= 1'b1;
      run_q    <= '0;
      filt_n_o <= 1'b1;
    end else begin
      s1_q <= pin_n_i;
      s2_q <= s1_q;
      if (s2_q == filt_n_o) begin
        run_q <= '0;
      end else if (at_lim) begin
        run_q    <= '0;
        filt_n_o <= s2_q;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rw_startup.sv
module rw_startup #(
  parameter int CNTW = 10
) (
  input  logic clk,
  input  logic por_i,
  input  logic hold_i,
  output logic busy_o
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      cnt_q  <= '0;
      busy_o <= 1'b1;
    end else if (hold_i) begin
      cnt_q  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt_q == {CNTW{1'b1}}) busy_o <= 1'b0;
      else                       cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rw_cause_decode.sv
module rw_cause_decode
  import rstwake_pkg::*;
#(
  parameter int PCW     = 13,
  parameter int IRQ_VEC = 4
) (
  input  logic           pin_fall_i,
  input  logic           wdt_i,
  input  logic           sleep_i,
  input  logic           int_pend_i,
  input  logic           gie_i,
  input  logic           mask_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [7:0]     status_i,
  output logic           fire_o,
  output cause_e         cause_o,
  output logic [PCW-1:0] pc_o,
  output logic [7:0]     status_o,
  output logic           rst_o
);
  logic [PCW-1:0] pc_inc;
  assign pc_inc = pc_i + 1'b1;

  always_comb begin
    fire_o   = 1'b0;
    cause_o  = CZ_NONE;
    pc_o     = '0;
    status_o = status_i;
    rst_o    = 1'b0;
    if (pin_fall_i) begin
      fire_o = 1'b1;
      rst_o  = 1'b1;
      if (sleep_i) begin
        cause_o  = CZ_PIN_SLP;
        status_o = {3'b000, 2'b10, status_i[2:0]};
      end else begin
        cause_o  = CZ_PIN_RUN;
        status_o = {3'b000, status_i[4:0]};
      end
    end else if (wdt_i && !mask_i) begin
      fire_o = 1'b1;
      if (sleep_i) begin
        cause_o  = CZ_WD_WAKE;
        pc_o     = pc_inc;
        status_o = {status_i[7:5], 2'b00, status_i[2:0]};
      end else begin
        cause_o  = CZ_WD_RUN;
        rst_o    = 1'b1;
        status_o = {5'b00001, status_i[2:0]};
      end
    end else if (int_pend_i && sleep_i && !mask_i) begin
      fire_o   = 1'b1;
      cause_o  = CZ_IRQ_WAKE;
      pc_o     = gie_i ? PCW'(IRQ_VEC) : pc_inc;
      status_o = {status_i[7:5], 2'b10, status_i[2:0]};
    end
  end
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
  import rstwake_pkg::*;
#(
  parameter int PCW     = 13,
  parameter int FILT_N  = 4,
  parameter int DLY_W   = 10,
  parameter int IRQ_VEC = 4
) (
  input  logic           clk,
  input  logic           por_i,
  input  logic           mclr_n_i,
  input  logic           wdt_to_i,
  input  logic           sleep_i,
  input  logic           int_pend_i,
  input  logic           gie_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [7:0]     status_i,
  output logic           evt_o,
  output logic [2:0]     cause_o,
  output logic [5:0]     cause_oh_o,
  output logic [PCW-1:0] pc_val_o,
  output logic [7:0]     status_o,
  output logic           chip_rst_o
);
  logic           filt_n, pin_fall, busy, rst_pulse_q;
  logic           d_fire, d_rst;
  cause_e         d_cause, cause_q;
  logic [PCW-1:0] d_pc;
  logic [7:0]     d_st;

  rw_pin_filter #(.N(FILT_N)) u_filt (
    .clk(clk), .por_i(por_i), .pin_n_i(mclr_n_i),
    .filt_n_o(filt_n), .fall_o(pin_fall)
  );

  rw_startup #(.CNTW(DLY_W)) u_dly (
    .clk(clk), .por_i(por_i), .hold_i(pin_fall || !filt_n), .busy_o(busy)
  );

  assign chip_rst_o = busy || rst_pulse_q;

  rw_cause_decode #(.PCW(PCW), .IRQ_VEC(IRQ_VEC)) u_dec (
    .pin_fall_i(pin_fall), .wdt_i(wdt_to_i), .sleep_i(sleep_i),
    .int_pend_i(int_pend_i), .gie_i(gie_i), .mask_i(chip_rst_o),
    .pc_i(pc_i), .status_i(status_i),
    .fire_o(d_fire), .cause_o(d_cause), .pc_o(d_pc),
    .status_o(d_st), .rst_o(d_rst)
  );

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      evt_o       <= 1'b1;
      cause_q     <= CZ_POR;
      pc_val_o    <= '0;
      status_o    <= POR_STATUS;
      rst_pulse_q <= 1'b0;
    end else begin
      evt_o       <= d_fire;
      cause_q     <= d_fire ? d_cause : CZ_NONE;
      pc_val_o    <= d_pc;
      status_o    <= d_st;
      rst_pulse_q <= d_fire && d_rst;
    end
  end

  assign cause_o = cause_q;

  for (genvar k = 0; k < NCAUSE; k++) begin : g_oh
    assign cause_oh_o[k] = evt_o && (cause_q == cause_e'(k + 1));
  end
endmodule

// File: rtl/rstwake_ctrl_chk.sv
module rstwake_ctrl_chk
  import rstwake_pkg::*;
#(
  parameter int PCW = 13
) (
  input logic           clk,
  input logic           por_i,
  input logic           wdt_to_i,
  input logic           sleep_i,
  input logic           int_pend_i,
  input logic           evt_o,
  input logic [2:0]     cause_o,
  input logic [5:0]     cause_oh_o,
  input logic [PCW-1:0] pc_val_o,
  input logic [7:0]     status_o,
  input logic           chip_rst_o
);
  p_oh_zero_r9: assert property (@(posedge clk) disable iff (por_i)
    !evt_o |-> cause_oh_o == 6'd0);

  p_oh_one_r9: assert property (@(posedge clk) disable iff (por_i)
    evt_o |-> $countones(cause_oh_o) == 1);

  p_reset_pc_r3: assert property (@(posedge clk) disable iff (por_i)
    (evt_o && (cause_o == CZ_PIN_RUN || cause_o == CZ_PIN_SLP || cause_o == CZ_WD_RUN))
      |-> pc_val_o == '0);

  p_pin_slp_r4: assert property (@(posedge clk) disable iff (por_i)
    (evt_o && cause_o == CZ_PIN_SLP) |-> status_o[7:3] == 5'b00010);

  p_wd_run_r5: assert property (@(posedge clk) disable iff (por_i)
    (evt_o && cause_o == CZ_WD_RUN) |-> chip_rst_o && status_o[4:3] == 2'b01);

  p_wd_wake_r6: assert property (@(posedge clk) disable iff (por_i)
    (evt_o && cause_o == CZ_WD_WAKE) |-> !chip_rst_o && status_o[4:3] == 2'b00);

  p_irq_wake_r7: assert property (@(posedge clk) disable iff (por_i)
    (evt_o && cause_o == CZ_IRQ_WAKE) |-> !chip_rst_o && status_o[4:3] == 2'b10);

  p_prio_r8: assert property (@(posedge clk) disable iff (por_i)
    (wdt_to_i && sleep_i && int_pend_i && !chip_rst_o) |=> cause_o != CZ_IRQ_WAKE);

  p_mask_r11: assert property (@(posedge clk) disable iff (por_i)
    ($past(chip_rst_o) && evt_o)
      |-> (cause_o == CZ_POR || cause_o == CZ_PIN_RUN || cause_o == CZ_PIN_SLP));
endmodule

bind rstwake_ctrl rstwake_ctrl_chk #(.PCW(PCW)) u_chk (.*);

// File: tb/rstwake_ctrl_tb.sv
module rstwake_ctrl_tb;
  localparam int PCW = 13;
  localparam int FN  = 4;
  localparam int DW  = 10;
  localparam int DLY = 1 << DW;

  logic clk = 1'b0;
  logic por_i = 1'b1, mclr_n_i = 1'b1, wdt_to_i = 1'b0, sleep_i = 1'b0;
  logic int_pend_i = 1'b0, gie_i = 1'b0;
  logic [PCW-1:0] pc_i = '0;
  logic [7:0] status_i = '0;
  logic evt_o, chip_rst_o;
  logic [2:0] cause_o;
  logic [5:0] cause_oh_o;
  logic [PCW-1:0] pc_val_o;
  logic [7:0] status_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstwake_ctrl #(.PCW(PCW), .FILT_N(FN), .DLY_W(DW), .IRQ_VEC(4)) u_dut (
    .clk(clk), .por_i(por_i), .mclr_n_i(mclr_n_i), .wdt_to_i(wdt_to_i),
    .sleep_i(sleep_i), .int_pend_i(int_pend_i), .gie_i(gie_i), .pc_i(pc_i),
    .status_i(status_i), .evt_o(evt_o), .cause_o(cause_o),
    .cause_oh_o(cause_oh_o), .pc_val_o(pc_val_o), .status_o(status_o),
    .chip_rst_o(chip_rst_o)
  );

  // kind: 0 watchdog pulse, 1 interrupt pulse, 2 master-clear press
  typedef struct packed {
    logic [1:0]     kind;
    logic           slp;
    logic           gie;
    logic [PCW-1:0] pc;
    logic [7:0]     st;
    logic [2:0]     ecz;
    logic [PCW-1:0] epc;
    logic [7:0]     est;
    logic           erst;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{2'd0, 1'b0, 1'b0, 13'h0123, 8'hE7, 3'd4, 13'h0000, 8'h0F, 1'b1}, // R5
    '{2'd0, 1'b1, 1'b0, 13'h0123, 8'hFF, 3'd5, 13'h0124, 8'hE7, 1'b0}, // R6
    '{2'd0, 1'b1, 1'b1, 13'h1FFF, 8'h18, 3'd5, 13'h0000, 8'h00, 1'b0}, // R6 wrap
    '{2'd1, 1'b1, 1'b0, 13'h0040, 8'h00, 3'd6, 13'h0041, 8'h10, 1'b0}, // R7
    '{2'd1, 1'b1, 1'b1, 13'h0040, 8'hEF, 3'd6, 13'h0004, 8'hF7, 1'b0}, // R7 vector
    '{2'd2, 1'b0, 1'b0, 13'h0555, 8'hFF, 3'd2, 13'h0000, 8'h1F, 1'b1}, // R3
    '{2'd2, 1'b1, 1'b0, 13'h0555, 8'hEF, 3'd3, 13'h0000, 8'h17, 1'b1}  // R4
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic wait_rst_low();
    for (int i = 0; i < DLY + 200; i++) begin
      if (!chip_rst_o) return;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      finish_run();
    end
  end

  initial begin
    int n;
    bit got;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "evt", 32'(evt_o), 1);
    chk("R1", "cause", 32'(cause_o), 1);
    chk("R9", "onehot", 32'(cause_oh_o), 32'h01);
    chk("R1", "pc", 32'(pc_val_o), 0);
    chk("R1", "status", 32'(status_o), 32'h18);
    chk("R1", "chip_rst", 32'(chip_rst_o), 1);
    por_i = 1'b0;
    // R11 watchdog ignored during start-up
    repeat (10) @(negedge clk);
    wdt_to_i = 1'b1;
    @(negedge clk); wdt_to_i = 1'b0;
    chk("R11", "evt during delay", 32'(evt_o), 0);
    @(negedge clk);
    chk("R11", "evt during delay+1", 32'(evt_o), 0);
    repeat (DLY - 1 - 12) @(negedge clk);
    chk("R1", "rst before release", 32'(chip_rst_o), 1);
    @(negedge clk);
    chk("R1", "rst at release", 32'(chip_rst_o), 0);

    // table walk
    for (int v = 0; v < 7; v++) begin
      sleep_i = TBL[v].slp; gie_i = TBL[v].gie;
      pc_i = TBL[v].pc; status_i = TBL[v].st;
      @(negedge clk);
      if (TBL[v].kind == 2'd0) wdt_to_i = 1'b1;
      else if (TBL[v].kind == 2'd1) int_pend_i = 1'b1;
      else mclr_n_i = 1'b0;
      got = 1'b0; n = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        wdt_to_i = 1'b0; int_pend_i = 1'b0;
        if (evt_o) begin
          n++;
          if (!got) begin
            got = 1'b1;
            chk("R9", "table cause", 32'(cause_o), 32'(TBL[v].ecz));
            chk("R9", "table onehot", 32'(cause_oh_o), 32'(1) << (TBL[v].ecz - 1));
            chk("R3", "table pc", 32'(pc_val_o), 32'(TBL[v].epc));
            chk("R3", "table status", 32'(status_o), 32'(TBL[v].est));
            chk("R5", "table chip_rst", 32'(chip_rst_o), 32'(TBL[v].erst));
          end
        end
      end
      chk("R3", "table event count", 32'(n), 1);
      mclr_n_i = 1'b1;
      sleep_i = 1'b0;
      wait_rst_low();
      @(negedge clk);
    end

    // R7 interrupt while awake is ignored
    int_pend_i = 1'b1;
    n = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (evt_o) n++;
    end
    int_pend_i = 1'b0;
    chk("R7", "irq awake events", 32'(n), 0);

    // R8 watchdog and interrupt in the same cycle during sleep
    sleep_i = 1'b1; gie_i = 1'b1; pc_i = 13'h0010; status_i = 8'h00;
    wdt_to_i = 1'b1; int_pend_i = 1'b1;
    @(negedge clk);
    wdt_to_i = 1'b0; int_pend_i = 1'b0;
    chk("R8", "coincident cause", 32'(cause_o), 5);
    chk("R8", "coincident pc", 32'(pc_val_o), 32'h11);
    sleep_i = 1'b0;
    repeat (2) @(negedge clk);

    // R2 short glitch of FN-1 cycles
    mclr_n_i = 1'b0;
    repeat (FN - 1) @(negedge clk);
    mclr_n_i = 1'b1;
    n = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (evt_o || chip_rst_o) n++;
    end
    chk("R2", "short glitch activity", 32'(n), 0);

    // R2 press of exactly FN cycles is accepted
    mclr_n_i = 1'b0;
    repeat (FN) @(negedge clk);
    mclr_n_i = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (evt_o && cause_o == 3'd2) got = 1'b1;
    end
    chk("R2", "FN press accepted", 32'(got), 1);
    wait_rst_low();
    @(negedge clk);

    // R10 release timing after a long press
    mclr_n_i = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10", "rst while held", 32'(chip_rst_o), 1);
    mclr_n_i = 1'b1;
    repeat (FN + 2 + DLY - 1) @(negedge clk);
    chk("R10", "rst before release", 32'(chip_rst_o), 1);
    @(negedge clk);
    chk("R10", "rst at release", 32'(chip_rst_o), 0);

    finish_run();
  end
endmodule